// File: doc/BRIEF.md
# Parallel-Access Shift Register with JK Serial Entry

This block is a small storage register, four stages wide by default, that moves data on the rising clock edge in one of two ways. A single transfer-select input picks the way. With the select high, the contents move one place per edge from stage 0 toward the last stage. With the select low, the whole register takes a parallel word in one edge. Shifting and loading can be mixed freely from cycle to cycle. This supports serial-to-parallel conversion, parallel-to-serial conversion, plain storage and counter-style feedback.

During a shift, stage 0 does not take a plain serial bit. Its next value comes from a J input and an active-low K input (K-bar), which are combined with the present stage 0 value by the usual JK rules. If J and K-bar are wired together, this reduces to a simple serial data input. A complemented copy of the last stage is also provided, so the register can drive a feedback path that needs the inverted tail bit, such as a twisted-ring counter.

An active-low master reset clears every stage at once, without waiting for a clock edge, and it overrides all other inputs. A shift toward stage 0 can be built outside the block: wire each stage output back to the parallel input one position lower and hold the select low.

Top module: `pa_shift_reg`

## Requirements
- R1: While `rst_n` is low, all stages of `q` are 0 and `q_last_n` is 1. Clearing takes effect as soon as `rst_n` falls, whatever the clock and the other inputs are doing.
- R2: With `shift_en` = 1 at a rising edge, each stage i ≥ 1 takes the value that stage i−1 held before that edge.
- R3: With `shift_en` = 0 at a rising edge, `q[i]` takes `par_d[i]` for every i.
- R4: With `shift_en` = 1, stage 0 follows {J, K-bar}. 00 gives 0 and 11 gives 1. 01 keeps the old stage 0 value and 10 inverts it.
- R5: When `j_in` equals `kb_in` during a shift, stage 0 takes that common value, so the pair acts as a plain serial data input.
- R6: `q_last_n` is always the inverse of the last stage `q[WIDTH-1]`.
- R7: `q` and `q_last_n` change only at a rising clock edge or on reset. Input changes between edges have no effect until the next edge.
- R8: The first rising edge after `rst_n` returns high performs a normal shift or load.
- R9: With `par_d[i]` wired to `q[i+1]` and `shift_en` = 0, each edge moves the data one place toward stage 0. The top stage takes whatever is driven on `par_d[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| shift_en | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| j_in | input | 1 | J input of the stage 0 entry logic |
| kb_in | input | 1 | Active-low K input of the stage 0 entry logic |
| par_d | input | WIDTH | Parallel load data, bit i to stage i |
| q | output | WIDTH | Stage outputs, bit 0 is the first stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
Every shift and load result is due one register stage after its stimulus. The bench drives inputs on the falling edge and computes the expected word from its own model of the previous state. It samples one nanosecond after the next rising edge, so each comparison sees exactly one transfer. Reset behaves differently: it is pulled low part way through a clock phase, and the outputs are checked a fraction of a nanosecond later, before any edge arrives, to show that clearing needs no clock. Reset is then released between edges, and the first edge afterwards is checked as an ordinary transfer. To confirm the between-edge behaviour, inputs are changed mid-phase and the outputs are sampled again before the next edge.

// File: rtl/pa_reg_pkg.sv
package pa_reg_pkg;

  // Transfer select encoding
  typedef enum logic {
    XFER_LOAD  = 1'b0,
    XFER_SHIFT = 1'b1
  } xfer_mode_e;

  // Encoding of the {J, K-bar} pair at the first stage
  typedef enum logic [1:0] {
    JK_CLEAR  = 2'b00,
    JK_HOLD   = 2'b01,
    JK_INVERT = 2'b10,
    JK_SET    = 2'b11
  } jk_code_e;

endpackage

// File: rtl/pa_entry_logic.sv
module pa_entry_logic
  import pa_reg_pkg::*;
(
  input  logic j_in,
  input  logic kb_in,
  input  logic cur_q0,
  output logic nxt_q0
);

  jk_code_e code;

  always_comb begin
    code = jk_code_e'({j_in, kb_in});
    unique case (code)
      JK_CLEAR:  nxt_q0 = 1'b0;
      JK_SET:    nxt_q0 = 1'b1;
      JK_HOLD:   nxt_q0 = cur_q0;
      JK_INVERT: nxt_q0 = ~cur_q0;
      default:   nxt_q0 = cur_q0;
    endcase
  end

endmodule

// File: rtl/pa_stage_bank.sv
module pa_stage_bank
  import pa_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             serial_nxt,
  input  logic [WIDTH-1:0] par_d,
  input  logic             j_in,
  input  logic             kb_in,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = WIDTH - 1;

  xfer_mode_e       mode;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  assign mode = xfer_mode_e'(shift_en);

  // Next-state selection, one multiplexer per stage
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb q_nxt[i] = (mode == XFER_SHIFT) ? serial_nxt : par_d[i];
      end else begin : g_body
        always_comb q_nxt[i] = (mode == XFER_SHIFT) ? q_r[i-1] : par_d[i];
      end
    end
  endgenerate

  // Register process, asynchronous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (q_r == '0));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q_r[LAST:1] == $past(q_r[LAST-1:0])));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (q_r == $past(par_d)));

  // R4
  jk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !j_in && kb_in) |=> (q_r[0] == $past(q_r[0])));

  // R4
  jk_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && j_in && !kb_in) |=> (q_r[0] != $past(q_r[0])));

  // R5
  d_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (j_in == kb_in)) |=> (q_r[0] == $past(j_in)));

endmodule

// File: rtl/pa_shift_reg.sv
module pa_shift_reg
  import pa_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             j_in,
  input  logic             kb_in,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  localparam int LAST = WIDTH - 1;

  logic             head_nxt;
  logic [WIDTH-1:0] stage_q;

  pa_entry_logic u_entry (
    .j_in   (j_in),
    .kb_in  (kb_in),
    .cur_q0 (stage_q[0]),
    .nxt_q0 (head_nxt)
  );

  pa_stage_bank #(.WIDTH(WIDTH)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .serial_nxt (head_nxt),
    .par_d      (par_d),
    .j_in       (j_in),
    .kb_in      (kb_in),
    .q          (stage_q)
  );

  assign q        = stage_q;
  assign q_last_n = ~stage_q[LAST];

  // R6
  tail_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (q_last_n != q[LAST]));

endmodule

// File: tb/test_pa_shift_reg.sv
`timescale 1ns/1ps
module test_pa_shift_reg;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         shift_en;
  logic         j_in;
  logic         kb_in;
  logic [W-1:0] par_d;
  logic [W-1:0] q;
  logic         q_last_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [W-1:0] mdl;

  always #2.5 clk = ~clk;

  pa_shift_reg #(.WIDTH(W)) i_pa_shift_reg (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .j_in(j_in),
    .kb_in(kb_in), .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic sh, logic j, logic kb, logic [W-1:0] d);
    logic h;
    if (!sh) return d;
    case ({j, kb})
      2'b00: h = 1'b0;
      2'b11: h = 1'b1;
      2'b01: h = cur[0];
      default: h = ~cur[0];
    endcase
    return {cur[W-2:0], h};
  endfunction

  // One edge: drive on falling edge, check just after the rising edge
  task automatic step(input string tag, input logic sh, input logic j, input logic kb, input logic [W-1:0] d);
    @(negedge clk);
    shift_en = sh; j_in = j; kb_in = kb; par_d = d;
    mdl = model_next(mdl, sh, j, kb, d);
    @(posedge clk);
    #1;
    chk(tag, q, mdl);
    chk({tag, " R6 tail"}, {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~mdl[W-1]});
  endtask

  task automatic test_reset();
    rst_n = 1'b0; shift_en = 1'b1; j_in = 1'b1; kb_in = 1'b1; par_d = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset q", q, '0);
    chk("R1 reset q_last_n", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
    @(negedge clk); #1.2;
    rst_n = 1'b1;
    mdl = '0;
  endtask

  task automatic test_load();
    step("R3 load a", 1'b0, 1'b0, 1'b0, 4'b1010);
    step("R3 load b", 1'b0, 1'b1, 1'b0, 4'b0101);
    step("R3 load c", 1'b0, 1'b1, 1'b1, 4'b1111);
    step("R3 load d", 1'b0, 1'b0, 1'b1, 4'b0000);
  endtask

  task automatic test_shift_d();
    step("R5 d=1", 1'b1, 1'b1, 1'b1, 4'b0000);
    step("R5 d=0", 1'b1, 1'b0, 1'b0, 4'b1111);
    step("R5 d=1", 1'b1, 1'b1, 1'b1, 4'b0000);
    step("R2 shift", 1'b1, 1'b1, 1'b1, 4'b0101);
    step("R2 shift", 1'b1, 1'b0, 1'b0, 4'b0101);
  endtask

  task automatic test_jk();
    step("R4 preload", 1'b0, 1'b0, 1'b0, 4'b0001);
    step("R4 hold 01", 1'b1, 1'b0, 1'b1, 4'b0000);
    step("R4 invert 10", 1'b1, 1'b1, 1'b0, 4'b1111);
    step("R4 invert 10", 1'b1, 1'b1, 1'b0, 4'b1111);
    step("R4 hold 01", 1'b1, 1'b0, 1'b1, 4'b0000);
    step("R4 set 11", 1'b1, 1'b1, 1'b1, 4'b0000);
    step("R4 clear 00", 1'b1, 1'b0, 1'b0, 4'b1111);
  endtask

  task automatic test_left_shift();
    step("R9 seed", 1'b0, 1'b0, 1'b0, 4'b1011);
    for (int k = 0; k < 5; k++) begin
      logic fill;
      fill = k[0];
      step("R9 left", 1'b0, 1'b0, 1'b0, {fill, q[W-1:1]});
    end
  endtask

  task automatic test_between_edges();
    @(negedge clk);
    shift_en = 1'b0; par_d = ~mdl; j_in = ~j_in; kb_in = ~kb_in;
    #1;
    par_d = 4'b0110; shift_en = 1'b1;
    #0.5;
    chk("R7 no change between edges", q, mdl);
    step("R7 after edge", 1'b0, 1'b0, 1'b0, 4'b1001);
  endtask

  task automatic test_async_reset();
    step("R1 prefill", 1'b0, 1'b0, 1'b0, 4'b1111);
    @(posedge clk); #1.3;
    mdl = model_next(mdl, shift_en, j_in, kb_in, par_d);
    rst_n = 1'b0;
    #0.4;
    chk("R1 async clear", q, '0);
    chk("R1 async q_last_n", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
    @(posedge clk); #0.7;
    rst_n = 1'b1;
    mdl = '0;
    chk("R1 held clear", q, '0);
    step("R8 first edge load", 1'b0, 1'b0, 1'b0, 4'b0110);
    step("R8 then shift", 1'b1, 1'b1, 1'b0, 4'b0000);
  endtask

  task automatic test_random();
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] rd;
      logic [2:0]   rc;
      rd = W'($urandom);
      rc = 3'($urandom);
      step("R2/R3/R4 random", rc[0], rc[1], rc[2], rd);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    mdl = '0;
    test_reset();
    test_load();
    test_shift_d();
    test_jk();
    test_left_shift();
    test_between_edges();
    test_async_reset();
    test_random();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule